// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a list of transfers without help from the host. The host fills a shared RAM with one command byte and one 16-bit transmit word per entry. It then sets a first and a last entry index and writes a start command. The engine fetches each entry in turn and drives the four chip-select outputs from the low bits of the command byte. It shifts the transmit word out on MOSI and stores the word captured from MISO back into the receive region at the same index. After each entry it records the index of the last entry that finished.

When the last entry is done, a sticky completion flag is set. If interrupts are enabled, the interrupt output is raised. Otherwise the engine stays idle until the host clears the flag and starts it again. A slave-select input can be enabled as a bus-contention detector: pulling it low during a run aborts the queue and sets a sticky fault flag.

Host addresses are 7 bits wide. Bits [6:5] select a region: 0 is command, 1 is transmit, 2 is receive and 3 is registers. Bits [4:0] give the entry index, or the register number in bits [1:0].

Top module: `spiq_master`

## Requirements
- R1: Command bytes (address 0x00+i, data bits [7:0]) and transmit words (0x20+i) are written by `host_wr` and read back by `host_rd`. Receive words are read at 0x40+i and cannot be written by the host. Read data appears on `host_rdata` on the clock edge after `host_rd` is sampled.
- R2: Writing 1 to bit 0 of register 0x63 while idle starts the queue. It begins at the start index (0x60 bits [4:0]) and runs every entry in ascending index order up to and including the end index (0x60 bits [12:8]). Each entry makes one 16-bit transfer.
- R3: SCK idles low. MOSI carries the transmit word MSB first and changes only after a falling SCK edge, with the first bit valid before the first rising edge. MISO is sampled on each rising edge. There are exactly 16 rising edges per entry.
- R4: Within a word, every high phase of SCK lasts div+1 clock cycles, and so does every low phase between bits. Here div is register 0x61 bits [7:0].
- R5: The word captured from MISO during an entry is written to the receive region at that entry's index.
- R6: While an entry transfers, PCS[3:0] equals command bits [3:0]. When the engine is idle, and after reset, PCS is 4'b1111.
- R7: If bit 7 of an entry's command is 0, PCS returns to 4'b1111 for at least one clock before the next entry. If bit 7 is 1, PCS keeps its value until the next entry drives its own value. After the final entry, PCS always returns to 4'b1111.
- R8: Status register 0x62 bits [12:8] hold the index of the most recently completed entry. After a full run this equals the end index.
- R9: When the start index is greater than the end index, the entry after index 31 is index 0.
- R10: At the end of the queue, status bit 0 (done) is set and bit 2 (busy) is cleared. The `irq` output is high exactly when (done or fault) is set and 0x61 bit 8 (interrupt enable) is 1.
- R11: Done and fault (status bit 1) stay set until the host writes 1 to that bit of 0x62. Writing 0 leaves them unchanged.
- R12: With 0x61 bit 9 set, `ss_n` low during a run sets fault and stops SCK low. It also returns PCS to 4'b1111 and ends the run with busy and done both clear. With bit 9 clear, `ss_n` has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 7 | Host address: region in [6:5], index or register in [4:0] |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, registered |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| pcs | output | 4 | Peripheral chip selects |
| ss_n | input | 1 | Slave-select input used for fault detection |
| irq | output | 1 | Completion or fault interrupt |

## Verification
The bench builds the block with its default parameters: 32 entries, 16-bit words, 8-bit commands, four chip selects and an 8-bit divider. With these values the full index range is reachable, so a queue from entry 30 to entry 1 exercises the wrap from 31 to 0. The divider is set at run time to 0, 1 and 3, which checks the SCK phase length for both the shortest and a longer setting. A bus-functional slave model supplies a distinct MISO word for each transfer, so the bench can tie every stored receive word and every observed chip-select value to its entry.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  typedef enum logic [1:0] {
    RGN_CMD = 2'd0,
    RGN_TX  = 2'd1,
    RGN_RX  = 2'd2,
    RGN_REG = 2'd3
  } spiq_region_e;

  typedef enum logic [1:0] {
    REG_PTR  = 2'd0,
    REG_CFG  = 2'd1,
    REG_STAT = 2'd2,
    REG_GO   = 2'd3
  } spiq_reg_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_LOAD,
    SQ_XFER
  } spiq_state_e;

  // command byte bit that keeps chip selects asserted between entries
  localparam int unsigned HOLD_BIT = 7;
  // low bit of the end index / completed index fields
  localparam int unsigned END_LSB  = 8;
  // status bits
  localparam int unsigned ST_DONE  = 0;
  localparam int unsigned ST_FAULT = 1;
  localparam int unsigned ST_BUSY  = 2;
  // configuration bits above the divider
  localparam int unsigned CFG_IRQ  = 8;
  localparam int unsigned CFG_SSEN = 9;
endpackage

// File: rtl/spiq_ram.sv
module spiq_ram
  import spiq_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CMD_W   = 8,
  parameter int unsigned NPCS    = 4,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cmd_we,
  input  logic              host_tx_we,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [CMD_W-1:0]  host_cmd_q,
  output logic [DATA_W-1:0] host_tx_q,
  output logic [DATA_W-1:0] host_rx_q,
  input  logic [IDX_W-1:0]  eng_idx,
  input  logic              eng_rd,
  output logic [NPCS-1:0]   eng_pcs_q,
  output logic              eng_hold_q,
  output logic [DATA_W-1:0] eng_tx_q,
  input  logic              eng_rx_we,
  input  logic [DATA_W-1:0] eng_rx_d
);
  logic [CMD_W-1:0]  cmd_mem [ENTRIES];
  logic [DATA_W-1:0] tx_mem  [ENTRIES];
  logic [DATA_W-1:0] rx_mem  [ENTRIES];

  // one storage slot per queue entry, each with its own write enables
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic cmd_en, tx_en, rx_en;
    assign cmd_en = host_cmd_we && (host_idx == IDX_W'(e));
    assign tx_en  = host_tx_we  && (host_idx == IDX_W'(e));
    assign rx_en  = eng_rx_we   && (eng_idx  == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (cmd_en) cmd_mem[e] <= host_wdata[CMD_W-1:0];
      if (tx_en)  tx_mem[e]  <= host_wdata;
      if (rx_en)  rx_mem[e]  <= eng_rx_d;
    end
  end

  assign host_cmd_q = cmd_mem[host_idx];
  assign host_tx_q  = tx_mem[host_idx];
  assign host_rx_q  = rx_mem[host_idx];

  // registered engine read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_pcs_q  <= '1;
      eng_hold_q <= 1'b0;
      eng_tx_q   <= '0;
    end else if (eng_rd) begin
      eng_pcs_q  <= cmd_mem[eng_idx][NPCS-1:0];
      eng_hold_q <= cmd_mem[eng_idx][HOLD_BIT];
      eng_tx_q   <= tx_mem[eng_idx];
    end
  end
endmodule

// File: rtl/spiq_shifter.sv
module spiq_shifter #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DIV_W  = 8,
  localparam int unsigned BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [DIV_W-1:0]  div,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic              busy_q, busy_d;
  logic              sck_q, sck_d;
  logic              done_q, done_d;
  logic [DIV_W-1:0]  half_q, half_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;

  always_comb begin
    busy_d = busy_q;
    sck_d  = sck_q;
    half_d = half_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (abort) begin
      busy_d = 1'b0;
      sck_d  = 1'b0;
      half_d = '0;
    end else if (start) begin
      busy_d = 1'b1;
      sck_d  = 1'b0;
      half_d = '0;
      bit_d  = '0;
      tx_d   = tx_word;
    end else if (busy_q) begin
      if (half_q == div) begin
        half_d = '0;
        sck_d  = !sck_q;
        if (!sck_q) begin
          rx_d = {rx_q[DATA_W-2:0], miso};
        end else if (bit_q == LAST_BIT) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
          tx_d  = {tx_q[DATA_W-2:0], 1'b0};
        end
      end else begin
        half_d = half_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      half_q <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      done_q <= done_d;
      half_q <= half_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign sck     = sck_q;
  assign mosi    = busy_q ? tx_q[DATA_W-1] : 1'b0;
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_word = rx_q;

  // R3
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q);

  // R3
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $fell(sck_q));
endmodule

// File: rtl/spiq_seq.sv
module spiq_seq
  import spiq_pkg::*;
#(
  parameter int unsigned IDX_W = 5,
  parameter int unsigned NPCS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [IDX_W-1:0] start_ptr,
  input  logic [IDX_W-1:0] end_ptr,
  input  logic             fault_en,
  input  logic             ss_n,
  input  logic [NPCS-1:0]  cmd_pcs,
  input  logic             cmd_hold,
  input  logic             sh_done,
  output logic [IDX_W-1:0] eng_idx,
  output logic             eng_rd,
  output logic             sh_start,
  output logic             sh_abort,
  output logic             rx_we,
  output logic [NPCS-1:0]  pcs,
  output logic [IDX_W-1:0] cptqp,
  output logic             busy,
  output logic             done_p,
  output logic             fault_p
);
  localparam logic [NPCS-1:0] PCS_IDLE = '1;

  spiq_state_e      state_q, state_d;
  logic [IDX_W-1:0] ip_q, ip_d;
  logic [IDX_W-1:0] cpt_q, cpt_d;
  logic [NPCS-1:0]  pcs_q, pcs_d;
  logic             hold_q, hold_d;
  logic [1:0]       ss_sync_q;
  logic             fault_now;

  assign fault_now = fault_en && !ss_sync_q[1] && (state_q != SQ_IDLE);

  always_comb begin
    state_d  = state_q;
    ip_d     = ip_q;
    cpt_d    = cpt_q;
    pcs_d    = pcs_q;
    hold_d   = hold_q;
    eng_rd   = 1'b0;
    sh_start = 1'b0;
    sh_abort = 1'b0;
    rx_we    = 1'b0;
    done_p   = 1'b0;
    fault_p  = 1'b0;
    if (fault_now) begin
      state_d  = SQ_IDLE;
      pcs_d    = PCS_IDLE;
      sh_abort = 1'b1;
      fault_p  = 1'b1;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (go) begin
            ip_d    = start_ptr;
            state_d = SQ_FETCH;
          end
        end
        SQ_FETCH: begin
          eng_rd  = 1'b1;
          state_d = SQ_LOAD;
        end
        SQ_LOAD: begin
          sh_start = 1'b1;
          pcs_d    = cmd_pcs;
          hold_d   = cmd_hold;
          state_d  = SQ_XFER;
        end
        SQ_XFER: begin
          if (sh_done) begin
            rx_we = 1'b1;
            cpt_d = ip_q;
            if (ip_q == end_ptr) begin
              state_d = SQ_IDLE;
              pcs_d   = PCS_IDLE;
              done_p  = 1'b1;
            end else begin
              ip_d    = ip_q + 1'b1;
              state_d = SQ_FETCH;
              if (!hold_q) pcs_d = PCS_IDLE;
            end
          end
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      ip_q      <= '0;
      cpt_q     <= '0;
      pcs_q     <= PCS_IDLE;
      hold_q    <= 1'b0;
      ss_sync_q <= 2'b11;
    end else begin
      state_q   <= state_d;
      ip_q      <= ip_d;
      cpt_q     <= cpt_d;
      pcs_q     <= pcs_d;
      hold_q    <= hold_d;
      ss_sync_q <= {ss_sync_q[0], ss_n};
    end
  end

  assign eng_idx = ip_q;
  assign pcs     = pcs_q;
  assign cptqp   = cpt_q;
  assign busy    = (state_q != SQ_IDLE);

  // R6
  pcs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE) |-> (pcs_q == PCS_IDLE));

  // R8
  done_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_p |=> (cpt_q == $past(end_ptr)));

  // R12
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_p |=> (state_q == SQ_IDLE));
endmodule

// File: rtl/spiq_master.sv
module spiq_master
  import spiq_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CMD_W   = 8,
  parameter int unsigned NPCS    = 4,
  parameter int unsigned DIV_W   = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NPCS-1:0]   pcs,
  input  logic              ss_n,
  output logic              irq
);
  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  spiq_region_e     region;
  spiq_reg_e        reg_sel;
  logic [IDX_W-1:0] host_idx;
  logic             wr_reg, cmd_we, tx_we, go, clr_done, clr_fault;

  logic [IDX_W-1:0]  start_q, start_d, end_q, end_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              irq_en_q, irq_en_d, ss_en_q, ss_en_d;
  logic              done_q, done_d, fault_q, fault_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic [CMD_W-1:0]  host_cmd_q;
  logic [DATA_W-1:0] host_tx_q, host_rx_q, eng_tx_q, rx_word;
  logic [NPCS-1:0]   eng_pcs_q;
  logic              eng_hold_q;
  logic [IDX_W-1:0]  eng_idx, cptqp;
  logic              eng_rd, sh_start, sh_abort, sh_done, sh_busy, rx_we;
  logic              busy, done_p, fault_p;

  assign region    = spiq_region_e'(host_addr[IDX_W+1:IDX_W]);
  assign reg_sel   = spiq_reg_e'(host_addr[1:0]);
  assign host_idx  = host_addr[IDX_W-1:0];
  assign wr_reg    = host_wr && (region == RGN_REG);
  assign cmd_we    = host_wr && (region == RGN_CMD);
  assign tx_we     = host_wr && (region == RGN_TX);
  assign go        = wr_reg && (reg_sel == REG_GO) && host_wdata[0] && !busy;
  assign clr_done  = wr_reg && (reg_sel == REG_STAT) && host_wdata[ST_DONE];
  assign clr_fault = wr_reg && (reg_sel == REG_STAT) && host_wdata[ST_FAULT];

  always_comb begin
    start_d  = start_q;
    end_d    = end_q;
    div_d    = div_q;
    irq_en_d = irq_en_q;
    ss_en_d  = ss_en_q;
    if (wr_reg && (reg_sel == REG_PTR)) begin
      start_d = host_wdata[IDX_W-1:0];
      end_d   = host_wdata[END_LSB +: IDX_W];
    end
    if (wr_reg && (reg_sel == REG_CFG)) begin
      div_d    = host_wdata[DIV_W-1:0];
      irq_en_d = host_wdata[CFG_IRQ];
      ss_en_d  = host_wdata[CFG_SSEN];
    end
    done_d  = done_p  | (done_q  & ~clr_done);
    fault_d = fault_p | (fault_q & ~clr_fault);
  end

  always_comb begin
    rdata_d = rdata_q;
    if (host_rd) begin
      rdata_d = '0;
      unique case (region)
        RGN_CMD: rdata_d[CMD_W-1:0] = host_cmd_q;
        RGN_TX:  rdata_d = host_tx_q;
        RGN_RX:  rdata_d = host_rx_q;
        default: begin
          unique case (reg_sel)
            REG_PTR: begin
              rdata_d[IDX_W-1:0]         = start_q;
              rdata_d[END_LSB +: IDX_W]  = end_q;
            end
            REG_CFG: begin
              rdata_d[DIV_W-1:0] = div_q;
              rdata_d[CFG_IRQ]   = irq_en_q;
              rdata_d[CFG_SSEN]  = ss_en_q;
            end
            REG_STAT: begin
              rdata_d[ST_DONE]           = done_q;
              rdata_d[ST_FAULT]          = fault_q;
              rdata_d[ST_BUSY]           = busy;
              rdata_d[END_LSB +: IDX_W]  = cptqp;
            end
            default: rdata_d = '0;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      start_q  <= '0;
      end_q    <= '0;
      div_q    <= '0;
      irq_en_q <= 1'b0;
      ss_en_q  <= 1'b0;
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
      rdata_q  <= '0;
    end else begin
      start_q  <= start_d;
      end_q    <= end_d;
      div_q    <= div_d;
      irq_en_q <= irq_en_d;
      ss_en_q  <= ss_en_d;
      done_q   <= done_d;
      fault_q  <= fault_d;
      rdata_q  <= rdata_d;
    end
  end

  assign host_rdata = rdata_q;
  assign irq        = irq_en_q && (done_q || fault_q);

  spiq_ram #(
    .ENTRIES (ENTRIES),
    .DATA_W  (DATA_W),
    .CMD_W   (CMD_W),
    .NPCS    (NPCS)
  ) ram_i (
    .clk         (clk),
    .rst_n       (rst_i),
    .host_cmd_we (cmd_we),
    .host_tx_we  (tx_we),
    .host_idx    (host_idx),
    .host_wdata  (host_wdata),
    .host_cmd_q  (host_cmd_q),
    .host_tx_q   (host_tx_q),
    .host_rx_q   (host_rx_q),
    .eng_idx     (eng_idx),
    .eng_rd      (eng_rd),
    .eng_pcs_q   (eng_pcs_q),
    .eng_hold_q  (eng_hold_q),
    .eng_tx_q    (eng_tx_q),
    .eng_rx_we   (rx_we),
    .eng_rx_d    (rx_word)
  );

  spiq_seq #(
    .IDX_W (IDX_W),
    .NPCS  (NPCS)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_i),
    .go        (go),
    .start_ptr (start_q),
    .end_ptr   (end_q),
    .fault_en  (ss_en_q),
    .ss_n      (ss_n),
    .cmd_pcs   (eng_pcs_q),
    .cmd_hold  (eng_hold_q),
    .sh_done   (sh_done),
    .eng_idx   (eng_idx),
    .eng_rd    (eng_rd),
    .sh_start  (sh_start),
    .sh_abort  (sh_abort),
    .rx_we     (rx_we),
    .pcs       (pcs),
    .cptqp     (cptqp),
    .busy      (busy),
    .done_p    (done_p),
    .fault_p   (fault_p)
  );

  spiq_shifter #(
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W)
  ) shf_i (
    .clk     (clk),
    .rst_n   (rst_i),
    .start   (sh_start),
    .abort   (sh_abort),
    .div     (div_q),
    .tx_word (eng_tx_q),
    .miso    (miso),
    .sck     (sck),
    .mosi    (mosi),
    .busy    (sh_busy),
    .done    (sh_done),
    .rx_word (rx_word)
  );

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (done_q && !clr_done) |=> done_q);

  // R12
  fault_no_sck_chk: assert property (@(posedge clk) disable iff (!rst_i)
    fault_p |=> (!sh_busy && !busy));
endmodule

// File: tb/spiq_master_tb_top.sv
`timescale 1ns/1ps
module spiq_master_tb_top;
  logic        clk;
  logic        rst_n;
  logic [6:0]  host_addr;
  logic        host_wr;
  logic        host_rd;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        sck;
  logic        mosi;
  logic        miso;
  logic [3:0]  pcs;
  logic        ss_n;
  logic        irq;

  spiq_master dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .sck        (sck),
    .mosi       (mosi),
    .miso       (miso),
    .pcs        (pcs),
    .ss_n       (ss_n),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  localparam logic [6:0] A_PTR  = 7'h60;
  localparam logic [6:0] A_CFG  = 7'h61;
  localparam logic [6:0] A_STAT = 7'h62;
  localparam logic [6:0] A_GO   = 7'h63;

  // slave model state, written only by the sampling block below
  logic [15:0] slv_words [64];
  logic [15:0] cap_word  [64];
  logic [3:0]  cap_pcs   [64];
  bit          idle_seen [64];
  int          cap_cnt, cap_bit, widx, bit_i, clr_seen, cyc, t_rise, t_fall;
  int          hi_min, hi_max, lo_min, lo_max;
  bit          idle_since, prev_sck;
  logic [15:0] cap_sh;
  int          clr_req = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (clr_seen != clr_req) begin
      clr_seen = clr_req;
      cap_cnt = 0; cap_bit = 0; widx = 0; bit_i = 0;
      idle_since = 1'b1; prev_sck = sck; cap_sh = '0;
      hi_min = 100000; hi_max = 0; lo_min = 100000; lo_max = 0;
      miso = slv_words[0][15];
    end else begin
      if (pcs == 4'hF) idle_since = 1'b1;
      if (sck && !prev_sck) begin
        if (cap_bit == 0) begin
          idle_seen[cap_cnt] = idle_since;
          idle_since = 1'b0;
        end else begin
          if (cyc - t_fall < lo_min) lo_min = cyc - t_fall;
          if (cyc - t_fall > lo_max) lo_max = cyc - t_fall;
        end
        t_rise = cyc;
        cap_sh = {cap_sh[14:0], mosi};
        cap_bit = cap_bit + 1;
        if (cap_bit == 16) begin
          cap_word[cap_cnt] = cap_sh;
          cap_pcs[cap_cnt] = pcs;
          cap_cnt = cap_cnt + 1;
          cap_bit = 0;
        end
      end
      if (!sck && prev_sck) begin
        if (cyc - t_rise < hi_min) hi_min = cyc - t_rise;
        if (cyc - t_rise > hi_max) hi_max = cyc - t_rise;
        t_fall = cyc;
        bit_i = bit_i + 1;
        if (bit_i == 16) begin
          bit_i = 0;
          widx = widx + 1;
        end
        miso = slv_words[widx][15 - bit_i];
      end
      prev_sck = sck;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic slave_clear();
    @(posedge clk);
    clr_req = clr_req + 1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [15:0] st;
    for (int k = 0; k < 4000; k++) begin
      hread(A_STAT, st);
      if (!st[2]) break;
    end
  endtask

  task automatic start_queue(input int s, input int e, input logic [15:0] cfg);
    hwrite(A_STAT, 16'h0003);
    hwrite(A_CFG, cfg);
    hwrite(A_PTR, 16'((e << 8) | s));
    slave_clear();
    hwrite(A_GO, 16'h0001);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R3 reset sck low", 32'(sck), 32'h0);
    chk("R3 reset mosi low", 32'(mosi), 32'h0);
    chk("R6 reset pcs idle", 32'(pcs), 32'hF);
    chk("R10 reset irq low", 32'(irq), 32'h0);
    hread(A_STAT, d);
    chk("R10 reset status", 32'(d), 32'h0);
  endtask

  task automatic t_mem();
    logic [15:0] d;
    hwrite(7'h05, 16'h00A5);
    hwrite(7'h25, 16'h1234);
    hread(7'h05, d);
    chk("R1 command readback", 32'(d), 32'h00A5);
    hread(7'h25, d);
    chk("R1 transmit readback", 32'(d), 32'h1234);
    hwrite(7'h45, 16'hBEEF);
    hwrite(7'h05, 16'h0000);
  endtask

  task automatic t_basic();
    logic [15:0] d;
    logic [15:0] tx [3] = '{16'hA55A, 16'h0001, 16'h8000};
    logic [3:0]  cs [3] = '{4'hE, 4'hD, 4'hB};
    slv_words[0] = 16'h1357; slv_words[1] = 16'hFFFF; slv_words[2] = 16'h0F0F;
    for (int i = 0; i < 3; i++) begin
      hwrite(7'(i), {12'h0, cs[i]});
      hwrite(7'(32 + i), tx[i]);
    end
    start_queue(0, 2, 16'h0000);
    wait_idle();
    chk("R2 transfer count", 32'(cap_cnt), 32'd3);
    for (int i = 0; i < 3; i++) begin
      chk("R3 mosi word", 32'(cap_word[i]), 32'(tx[i]));
      chk("R6 pcs during entry", 32'(cap_pcs[i]), 32'(cs[i]));
      hread(7'(64 + i), d);
      chk("R5 receive word", 32'(d), 32'(slv_words[i]));
    end
    chk("R7 idle gap before entry 1", 32'(idle_seen[1]), 32'h1);
    chk("R7 idle gap before entry 2", 32'(idle_seen[2]), 32'h1);
    chk("R4 high phase div0 min", 32'(hi_min), 32'd1);
    chk("R4 high phase div0 max", 32'(hi_max), 32'd1);
    chk("R4 low phase div0 max", 32'(lo_max), 32'd1);
    hread(A_STAT, d);
    chk("R8 R10 status after run", 32'(d), 32'h0201);
    chk("R10 irq low when disabled", 32'(irq), 32'h0);
    chk("R6 pcs idle after run", 32'(pcs), 32'hF);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    hwrite(A_CFG, 16'h0100);
    @(negedge clk);
    chk("R10 irq with done and enable", 32'(irq), 32'h1);
    hwrite(A_STAT, 16'h0000);
    hread(A_STAT, d);
    chk("R11 write 0 keeps done", 32'(d[0]), 32'h1);
    hwrite(A_STAT, 16'h0001);
    hread(A_STAT, d);
    chk("R11 write 1 clears done", 32'(d[0]), 32'h0);
    chk("R10 irq low after clear", 32'(irq), 32'h0);
  endtask

  task automatic t_div();
    logic [15:0] d;
    slv_words[0] = 16'hC3A5;
    hwrite(7'h04, 16'h0007);
    hwrite(7'h24, 16'h5AC3);
    start_queue(4, 4, 16'h0003);
    wait_idle();
    chk("R3 div3 mosi word", 32'(cap_word[0]), 32'h5AC3);
    chk("R4 high phase div3 min", 32'(hi_min), 32'd4);
    chk("R4 high phase div3 max", 32'(hi_max), 32'd4);
    chk("R4 low phase div3 min", 32'(lo_min), 32'd4);
    chk("R4 low phase div3 max", 32'(lo_max), 32'd4);
    hread(7'h44, d);
    chk("R5 receive word div3", 32'(d), 32'hC3A5);
  endtask

  task automatic t_hold();
    logic [15:0] d;
    slv_words[0] = 16'h0101; slv_words[1] = 16'h0202; slv_words[2] = 16'h0303;
    hwrite(7'h06, 16'h0086);
    hwrite(7'h07, 16'h0085);
    hwrite(7'h08, 16'h008C);
    hwrite(7'h26, 16'h1111);
    hwrite(7'h27, 16'h2222);
    hwrite(7'h28, 16'h3333);
    start_queue(6, 8, 16'h0001);
    wait_idle();
    chk("R2 hold run count", 32'(cap_cnt), 32'd3);
    chk("R7 no idle after held entry 6", 32'(idle_seen[1]), 32'h0);
    chk("R7 no idle after held entry 7", 32'(idle_seen[2]), 32'h0);
    chk("R6 pcs for entry 7", 32'(cap_pcs[1]), 32'h5);
    chk("R6 pcs for entry 8", 32'(cap_pcs[2]), 32'hC);
    chk("R7 pcs idle after last held entry", 32'(pcs), 32'hF);
    hread(A_STAT, d);
    chk("R8 completed index hold run", 32'(d[12:8]), 32'd8);
  endtask

  task automatic t_wrap();
    logic [15:0] d;
    int idx [4] = '{30, 31, 0, 1};
    for (int i = 0; i < 4; i++) begin
      slv_words[i] = 16'(16'hA000 + i);
      hwrite(7'(idx[i]), 16'h000E);
      hwrite(7'(32 + idx[i]), 16'(16'h0500 + idx[i]));
    end
    start_queue(30, 1, 16'h0000);
    wait_idle();
    chk("R9 wrap transfer count", 32'(cap_cnt), 32'd4);
    for (int i = 0; i < 4; i++) begin
      chk("R9 wrap order", 32'(cap_word[i]), 32'(16'h0500 + idx[i]));
      hread(7'(64 + idx[i]), d);
      chk("R5 R9 wrap receive", 32'(d), 32'(16'hA000 + i));
    end
    hread(A_STAT, d);
    chk("R8 completed index after wrap", 32'(d[12:8]), 32'd1);
  endtask

  task automatic t_fault();
    logic [15:0] d;
    slv_words[0] = 16'h1111; slv_words[1] = 16'h2222;
    hwrite(7'h0A, 16'h0006);
    hwrite(7'h0B, 16'h0006);
    start_queue(10, 11, 16'h0203);
    repeat (30) @(negedge clk);
    ss_n = 1'b0;
    repeat (8) @(negedge clk);
    chk("R12 sck stopped low", 32'(sck), 32'h0);
    chk("R12 pcs idle after fault", 32'(pcs), 32'hF);
    hread(A_STAT, d);
    chk("R12 fault set, done and busy clear", 32'(d[2:0]), 32'h2);
    ss_n = 1'b1;
    hwrite(A_STAT, 16'h0002);
    hread(A_STAT, d);
    chk("R11 fault cleared by write 1", 32'(d[2:0]), 32'h0);
  endtask

  task automatic t_ss_ignored();
    logic [15:0] d;
    slv_words[0] = 16'h6C6C;
    hwrite(7'h0C, 16'h0009);
    hwrite(7'h2C, 16'h9A9A);
    ss_n = 1'b0;
    start_queue(12, 12, 16'h0001);
    wait_idle();
    chk("R12 ss ignored word sent", 32'(cap_word[0]), 32'h9A9A);
    hread(7'h4C, d);
    chk("R12 ss ignored word received", 32'(d), 32'h6C6C);
    hread(A_STAT, d);
    chk("R12 ss ignored status", 32'(d[2:0]), 32'h1);
    ss_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; host_addr = '0; host_wr = 1'b0; host_rd = 1'b0;
    host_wdata = '0; ss_n = 1'b1;
    for (int i = 0; i < 64; i++) slv_words[i] = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_mem();
    t_basic();
    t_irq();
    t_div();
    t_hold();
    t_wrap();
    t_fault();
    t_ss_ignored();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
      $finish;
    end
  end
endmodule